// File: doc/BRIEF.md
# Subword Arithmetic Right-Shift Unit

This unit shifts a 32-bit source right by a variable count and folds the shifted value into a third operand through one of several second-stage operations. The source may be the whole word, one halfword, or one byte, and it may be signed or unsigned. The lane is extended to 33 bits, shifted, and widened to a 34-bit signed intermediate. That intermediate can be saturated to a signed or unsigned destination range. It is then passed through, merged into a lane of operand C, accumulated with C, or compared with C for a minimum or maximum.

The shift count comes from a lane of operand B or from a 16-bit immediate. One count policy clamps the count to 32. The other masks the count to its five low bits. The result and the zero, negative and clip flags are registered, so the result appears one clock after the operands are presented. Software-visible decode, predication and issue belong to the surrounding pipeline.

Top module: `sws_shr_unit`

## Requirements
- R1: While `rst_n` is low, `res`, `flag_z`, `flag_n` and `flag_v` are all 0.
- R2: The lane of A is chosen by `a_size`: 0 or 3 selects the word, 1 selects a halfword, 2 selects a byte. For a halfword, `a_part[0]` picks bits 15:0 (0) or 31:16 (1). For a byte, `a_part` picks bits `8*a_part+7 : 8*a_part`. The lane is sign-extended when `a_signed`=1 and zero-extended otherwise.
- R3: The raw count is the zero-extended `imm_val` when `use_imm`=1. Otherwise it is the zero-extended lane of B, selected by `b_size` and `b_part` with the same encoding as in R2.
- R4: With `count_wrap`=0, the count is min(raw, 32). A count of 32 yields all ones for a negative signed lane and 0 for every other lane.
- R5: With `count_wrap`=1, the count is raw AND 31. A raw count of 32 therefore returns the extended lane unshifted.
- R6: `op_sel` 0 (pass) returns the low 32 bits of the shifted value. When `sat_en`=1, that value is first clamped to [-2^31, 2^31-1] if `dst_signed`=1, or to [0, 2^32-1] if `dst_signed`=0.
- R7: `op_sel` 1, 2, 3 and 4 insert the shifted value into C at bits 31:16, 15:0, 7:0 and 23:16 respectively, and keep C's other bits. With `sat_en`=1, the inserted value is first clamped to the lane width (16 or 8 bits) in the destination signedness.
- R8: `op_sel` 5 adds C to the unsaturated shifted value. C is taken as signed when `dst_signed`=1 and unsigned otherwise. The sum is then saturated to 32 bits per R6 when `sat_en`=1, or truncated to 32 bits otherwise.
- R9: `op_sel` 6 returns the minimum and `op_sel` 7 returns the maximum of C and the R6 pass value. The comparison is signed when `dst_signed`=1 and unsigned otherwise.
- R10: When `cc_en`=1, the next clock sets `flag_z` = (result==0), `flag_n` = result bit 31, and `flag_v` = 1 only if saturation changed the value. When `cc_en`=0, all three flags hold their values.
- R11: The result of the operands presented before a rising clock edge appears on `res` after that edge, and `res` does not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_val | input | 32 | Operand to be shifted |
| b_val | input | 32 | Register count operand |
| c_val | input | 32 | Second-stage operand |
| imm_val | input | 16 | Immediate count |
| use_imm | input | 1 | 1: count from immediate |
| a_size | input | 2 | A lane size (0/3 word, 1 half, 2 byte) |
| a_signed | input | 1 | A lane is signed |
| a_part | input | 2 | A lane index |
| b_size | input | 2 | B lane size |
| b_part | input | 2 | B lane index |
| count_wrap | input | 1 | 0: clamp to 32, 1: mask to 5 bits |
| dst_signed | input | 1 | Destination is signed |
| sat_en | input | 1 | Saturate to destination range |
| op_sel | input | 3 | Second-stage operation |
| cc_en | input | 1 | Update flags |
| res | output | 32 | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Saturation clip flag |

## Verification
The bench targets several corner cases:
- Counts of exactly 31, 32 and above 32 under both count policies. A unit that masked instead of clamping would return the unshifted word, and one that stopped at 31 would leave a stray low bit.
- Unsigned word sources with the top bit set, routed to a signed saturating destination. A unit that lost the 34-bit widening would treat these as negative and clip the wrong way.
- Every merge lane. A unit that mis-positioned a lane or saturated to 32 bits instead of the lane width would corrupt the neighbouring bits of C.
- Accumulate, min and max with mixed signedness, where a wrong comparison type swaps the winner.
- Cycles with flag updates disabled, where the flags must hold their values.

// File: rtl/sws_pkg.sv
package sws_pkg;
   typedef enum logic [2:0] {
      OP_PASS = 3'd0,
      OP_MHI  = 3'd1,
      OP_MLO  = 3'd2,
      OP_MB0  = 3'd3,
      OP_MB2  = 3'd4,
      OP_ACC  = 3'd5,
      OP_MIN  = 3'd6,
      OP_MAX  = 3'd7
   } sws_op_e;

   typedef enum logic [1:0] {
      SZ_WORD = 2'd0,
      SZ_HALF = 2'd1,
      SZ_BYTE = 2'd2,
      SZ_RSVD = 2'd3
   } sws_size_e;
endpackage

// File: rtl/sws_extract.sv
module sws_extract
   import sws_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic [DW-1:0] src,
   input  logic [1:0]    size,
   input  logic [1:0]    part,
   input  logic          sgn,
   output logic [DW:0]   ext
);
   localparam int HW     = DW / 2;
   localparam int QW     = DW / 4;
   localparam int NHALF  = 2;
   localparam int NQUART = 4;

   logic [HW-1:0] halves [NHALF];
   logic [QW-1:0] quarts [NQUART];

   for (genvar g = 0; g < NHALF; g++) begin : g_half
      assign halves[g] = src[g*HW +: HW];
   end
   for (genvar g = 0; g < NQUART; g++) begin : g_quart
      assign quarts[g] = src[g*QW +: QW];
   end

   logic [HW-1:0] hsel;
   logic [QW-1:0] qsel;

   always_comb begin
      hsel = halves[part[0]];
      qsel = quarts[part];
      unique case (sws_size_e'(size))
         SZ_HALF: ext = {{(DW+1-HW){sgn & hsel[HW-1]}}, hsel};
         SZ_BYTE: ext = {{(DW+1-QW){sgn & qsel[QW-1]}}, qsel};
         default: ext = {sgn & src[DW-1], src};
      endcase
   end
endmodule

// File: rtl/sws_count.sv
module sws_count #(
   parameter int DW   = 32,
   parameter int IMMW = 16,
   parameter int NW   = 6
) (
   input  logic [DW:0]     b_lane,
   input  logic [IMMW-1:0] imm,
   input  logic            use_imm,
   input  logic            wrap,
   output logic [NW-1:0]   cnt
);
   localparam int RW = (DW + 1 > IMMW) ? DW + 1 : IMMW;

   logic [RW-1:0] raw;

   always_comb begin
      raw = use_imm ? RW'(imm) : RW'(b_lane);
      if (wrap)
         cnt = NW'(raw & RW'(DW - 1));
      else if (raw > RW'(DW))
         cnt = NW'(DW);
      else
         cnt = NW'(raw);
   end
endmodule

// File: rtl/sws_stage2.sv
module sws_stage2
   import sws_pkg::*;
#(
   parameter int DW = 32,
   parameter int NW = 6
) (
   input  logic signed [DW+1:0] shv,
   input  logic [DW-1:0]        c,
   input  logic                 d_signed,
   input  logic                 sat,
   input  logic [2:0]           op,
   output logic [DW-1:0]        result,
   output logic                 clip
);
   localparam int SW = DW + 3;
   localparam int HW = DW / 2;
   localparam int QW = DW / 4;

   logic signed [SW-1:0] v_ext, c_ext, acc_sum, src, hi, lo;
   logic [NW-1:0]        lane_w, hi_pow;
   logic [DW-1:0]        sval;
   logic                 over, under, lt;

   always_comb begin
      v_ext   = {shv[DW+1], shv};
      c_ext   = {{3{d_signed & c[DW-1]}}, c};
      acc_sum = v_ext + c_ext;
      src     = (sws_op_e'(op) == OP_ACC) ? acc_sum : v_ext;

      unique case (sws_op_e'(op))
         OP_MHI, OP_MLO: lane_w = NW'(HW);
         OP_MB0, OP_MB2: lane_w = NW'(QW);
         default:        lane_w = NW'(DW);
      endcase

      hi_pow = d_signed ? lane_w - NW'(1) : lane_w;
      hi     = $signed((SW'(1) << hi_pow) - SW'(1));
      lo     = d_signed ? -$signed(SW'(1) << (lane_w - NW'(1))) : '0;
      over   = sat && (src > hi);
      under  = sat && (src < lo);
      sval   = over ? hi[DW-1:0] : (under ? lo[DW-1:0] : src[DW-1:0]);
      clip   = over | under;

      lt = d_signed ? ($signed(sval) < $signed(c)) : (sval < c);

      unique case (sws_op_e'(op))
         OP_MHI:  result = {sval[HW-1:0], c[HW-1:0]};
         OP_MLO:  result = {c[DW-1:HW], sval[HW-1:0]};
         OP_MB0:  result = {c[DW-1:QW], sval[QW-1:0]};
         OP_MB2:  result = {c[DW-1:3*QW], sval[QW-1:0], c[2*QW-1:0]};
         OP_MIN:  result = lt ? sval : c;
         OP_MAX:  result = lt ? c : sval;
         default: result = sval;
      endcase
   end
endmodule

// File: rtl/sws_shr_unit.sv
module sws_shr_unit
   import sws_pkg::*;
#(
   parameter int DW   = 32,
   parameter int IMMW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DW-1:0]   a_val,
   input  logic [DW-1:0]   b_val,
   input  logic [DW-1:0]   c_val,
   input  logic [IMMW-1:0] imm_val,
   input  logic            use_imm,
   input  logic [1:0]      a_size,
   input  logic            a_signed,
   input  logic [1:0]      a_part,
   input  logic [1:0]      b_size,
   input  logic [1:0]      b_part,
   input  logic            count_wrap,
   input  logic            dst_signed,
   input  logic            sat_en,
   input  logic [2:0]      op_sel,
   input  logic            cc_en,
   output logic [DW-1:0]   res,
   output logic            flag_z,
   output logic            flag_n,
   output logic            flag_v
);
   localparam int NW = $clog2(DW) + 1;

   if ((DW < 8) || ((DW & (DW - 1)) != 0)) begin : g_bad_dw
      $error("sws_shr_unit: DW must be a power of two of at least 8");
   end
   if (IMMW < NW) begin : g_bad_immw
      $error("sws_shr_unit: IMMW too narrow to express a full count");
   end

   logic [DW:0]           a_ext, b_ext;
   logic [NW-1:0]         cnt;
   logic signed [DW+1:0]  a_wide, shv;
   logic [DW-1:0]         nxt_res;
   logic                  nxt_clip;

   sws_extract #(.DW(DW)) u_a_lane (
      .src(a_val), .size(a_size), .part(a_part), .sgn(a_signed), .ext(a_ext)
   );

   sws_extract #(.DW(DW)) u_b_lane (
      .src(b_val), .size(b_size), .part(b_part), .sgn(1'b0), .ext(b_ext)
   );

   sws_count #(.DW(DW), .IMMW(IMMW), .NW(NW)) u_count (
      .b_lane(b_ext), .imm(imm_val), .use_imm(use_imm), .wrap(count_wrap), .cnt(cnt)
   );

   always_comb begin
      a_wide = {a_ext[DW], a_ext};
      shv    = a_wide >>> cnt;
   end

   sws_stage2 #(.DW(DW), .NW(NW)) u_stage2 (
      .shv(shv), .c(c_val), .d_signed(dst_signed), .sat(sat_en),
      .op(op_sel), .result(nxt_res), .clip(nxt_clip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res    <= '0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
         flag_v <= 1'b0;
      end else begin
         res <= nxt_res;
         if (cc_en) begin
            flag_z <= (nxt_res == '0);
            flag_n <= nxt_res[DW-1];
            flag_v <= nxt_clip;
         end
      end
   end
endmodule

// File: rtl/sws_shr_unit_chk.sv
module sws_shr_unit_chk #(
   parameter int DW   = 32,
   parameter int IMMW = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic [DW-1:0]   a_val,
   input logic [DW-1:0]   b_val,
   input logic [DW-1:0]   c_val,
   input logic [IMMW-1:0] imm_val,
   input logic            use_imm,
   input logic [1:0]      a_size,
   input logic            a_signed,
   input logic [1:0]      b_size,
   input logic            count_wrap,
   input logic            sat_en,
   input logic [2:0]      op_sel,
   input logic            cc_en,
   input logic [DW-1:0]   res,
   input logic            flag_z,
   input logic            flag_n,
   input logic            flag_v
);
   localparam int HW = DW / 2;
   localparam int QW = DW / 4;

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cc_en |=> ($stable(flag_z) && $stable(flag_n) && $stable(flag_v)));

   a_r10_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cc_en |=> (flag_z == (res == '0)));

   a_r10_sign: assert property (@(posedge clk) disable iff (!rst_n)
      cc_en |=> (flag_n == res[DW-1]));

   a_r10_no_clip: assert property (@(posedge clk) disable iff (!rst_n)
      (cc_en && !sat_en) |=> !flag_v);

   a_r4_full_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_wrap && !use_imm && b_size == 2'd0 && b_val >= DW && a_size == 2'd0
       && op_sel == 3'd0 && !sat_en)
      |=> (res == (($past(a_signed) && $past(a_val[DW-1])) ? {DW{1'b1}} : {DW{1'b0}})));

   a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (count_wrap && use_imm && ((imm_val & IMMW'(DW - 1)) == '0) && a_size == 2'd0
       && op_sel == 3'd0 && !sat_en)
      |=> (res == $past(a_val)));

   a_r7_hi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd1) |=> (res[HW-1:0] == $past(c_val[HW-1:0])));

   a_r7_b2_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
      (op_sel == 3'd4) |=> ((res[2*QW-1:0] == $past(c_val[2*QW-1:0]))
                            && (res[DW-1:3*QW] == $past(c_val[DW-1:3*QW]))));
endmodule

bind sws_shr_unit sws_shr_unit_chk #(.DW(DW), .IMMW(IMMW)) u_chk (
   .clk(clk), .rst_n(rst_n), .a_val(a_val), .b_val(b_val), .c_val(c_val),
   .imm_val(imm_val), .use_imm(use_imm), .a_size(a_size), .a_signed(a_signed),
   .b_size(b_size), .count_wrap(count_wrap), .sat_en(sat_en), .op_sel(op_sel),
   .cc_en(cc_en), .res(res), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
);

// File: tb/sim_sws_shr_unit.sv
module sim_sws_shr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] a_val = '0, b_val = '0, c_val = '0;
   logic [15:0] imm_val = '0;
   logic        use_imm = 0, a_signed = 0, count_wrap = 0, dst_signed = 0, sat_en = 0, cc_en = 0;
   logic [1:0]  a_size = '0, a_part = '0, b_size = '0, b_part = '0;
   logic [2:0]  op_sel = '0;
   logic [31:0] res;
   logic        flag_z, flag_n, flag_v;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_res = '0;
   bit          exp_z = 0, exp_n = 0, exp_v = 0;

   always #5 clk = ~clk;

   sws_shr_unit u0 (
      .clk(clk), .rst_n(rst_n), .a_val(a_val), .b_val(b_val), .c_val(c_val),
      .imm_val(imm_val), .use_imm(use_imm), .a_size(a_size), .a_signed(a_signed),
      .a_part(a_part), .b_size(b_size), .b_part(b_part), .count_wrap(count_wrap),
      .dst_signed(dst_signed), .sat_en(sat_en), .op_sel(op_sel), .cc_en(cc_en),
      .res(res), .flag_z(flag_z), .flag_n(flag_n), .flag_v(flag_v)
   );

   function automatic longint lane_of(logic [31:0] v, logic [1:0] sz, logic [1:0] pt, bit sg);
      longint x;
      if (sz == 2'd1) begin
         x = longint'((v >> (pt[0] * 16)) & 32'hFFFF);
         if (sg && x >= 32768) x -= 65536;
      end else if (sz == 2'd2) begin
         x = longint'((v >> (pt * 8)) & 32'hFF);
         if (sg && x >= 128) x -= 256;
      end else begin
         x = longint'(v);
         if (sg && x >= 64'sh8000_0000) x -= 64'sh1_0000_0000;
      end
      return x;
   endfunction

   function automatic longint clampv(longint x, int n, bit sg, bit en, output bit clipped);
      longint hi, lo;
      hi = sg ? (longint'(1) <<< (n - 1)) - 1 : (longint'(1) <<< n) - 1;
      lo = sg ? -(longint'(1) <<< (n - 1)) : 0;
      clipped = 0;
      if (en && x > hi) begin clipped = 1; return hi; end
      if (en && x < lo) begin clipped = 1; return lo; end
      return x;
   endfunction

   task automatic model(output logic [31:0] r, output bit clipped);
      longint av, raw, cnt, sh, cv, x, m, pos;
      int w;
      av  = lane_of(a_val, a_size, a_part, a_signed);
      raw = use_imm ? longint'(imm_val) : lane_of(b_val, b_size, b_part, 1'b0);
      cnt = count_wrap ? (raw % 32) : (raw > 32 ? 32 : raw);
      sh  = av >>> cnt;
      cv  = lane_of(c_val, 2'd0, 2'd0, dst_signed);
      clipped = 0;
      case (op_sel)
         3'd1, 3'd2, 3'd3, 3'd4: begin
            w   = (op_sel <= 3'd2) ? 16 : 8;
            pos = (op_sel == 3'd1) ? 16 : (op_sel == 3'd4) ? 16 : 0;
            x   = clampv(sh, w, dst_signed, sat_en, clipped);
            m   = (longint'(1) <<< w) - 1;
            r   = 32'((longint'(c_val) & ~(m <<< pos)) | ((x & m) <<< pos));
         end
         3'd5: r = 32'(clampv(sh + cv, 32, dst_signed, sat_en, clipped));
         3'd6, 3'd7: begin
            x = clampv(sh, 32, dst_signed, sat_en, clipped);
            x = lane_of(32'(x), 2'd0, 2'd0, dst_signed);
            if (op_sel == 3'd6) r = 32'((x < cv) ? x : cv);
            else                r = 32'((x < cv) ? cv : x);
         end
         default: r = 32'(clampv(sh, 32, dst_signed, sat_en, clipped));
      endcase
   endtask

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive at negedge, verify output unchanged, then compare at next negedge
   task automatic step(string tag);
      logic [31:0] r;
      bit cl;
      model(r, cl);
      #1 check("R11", "res held between edges", res, exp_res);
      exp_res = r;
      if (cc_en) begin
         exp_z = (r == 0);
         exp_n = r[31];
         exp_v = cl;
      end
      @(negedge clk);
      check(tag, "res", res, exp_res);
      check("R10", "flags", {29'd0, flag_z, flag_n, flag_v}, {29'd0, exp_z, exp_n, exp_v});
   endtask

   task automatic put(logic [31:0] a, logic [31:0] b, logic [31:0] c, logic [15:0] im,
                      bit ui, logic [1:0] asz, bit asg, logic [1:0] apt,
                      logic [1:0] bsz, logic [1:0] bpt, bit wr, bit ds, bit st,
                      logic [2:0] op, bit cc);
      a_val = a; b_val = b; c_val = c; imm_val = im; use_imm = ui;
      a_size = asz; a_signed = asg; a_part = apt; b_size = bsz; b_part = bpt;
      count_wrap = wr; dst_signed = ds; sat_en = st; op_sel = op; cc_en = cc;
   endtask

   function automatic string rand_tag(logic [2:0] op, bit st, bit wr);
      if (op >= 3'd1 && op <= 3'd4) return "R7";
      if (op == 3'd5) return "R8";
      if (op >= 3'd6) return "R9";
      if (st) return "R6";
      return wr ? "R5" : "R4";
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "res in reset", res, 32'd0);
      check("R1", "flags in reset", {29'd0, flag_z, flag_n, flag_v}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 lane selection and extension
      put(32'h80F0_7F81, 32'd1, 0, 0, 0, 2'd2, 1, 2'd1, 0, 0, 0, 1, 0, 3'd0, 1); step("R2");
      put(32'h80F0_7F81, 32'd1, 0, 0, 0, 2'd2, 1, 2'd0, 0, 0, 0, 1, 0, 3'd0, 1); step("R2");
      put(32'h80F0_7F81, 32'd4, 0, 0, 0, 2'd1, 1, 2'd1, 0, 0, 0, 1, 0, 3'd0, 1); step("R2");
      put(32'h80F0_7F81, 32'd4, 0, 0, 0, 2'd1, 0, 2'd1, 0, 0, 0, 1, 0, 3'd0, 1); step("R2");
      put(32'h80F0_7F81, 32'd0, 0, 0, 0, 2'd3, 1, 2'd0, 0, 0, 0, 1, 0, 3'd0, 1); step("R2");
      // R3 count sources
      put(32'hFFFF_0000, 32'hFFFF_FF00, 0, 16'd9, 1, 2'd0, 0, 0, 2'd1, 2'd0, 0, 0, 0, 3'd0, 1); step("R3");
      put(32'hFFFF_0000, 32'h0003_0007, 0, 0, 0, 2'd0, 0, 0, 2'd1, 2'd1, 0, 0, 0, 3'd0, 1); step("R3");
      put(32'hFFFF_0000, 32'h0502_0000, 0, 0, 0, 2'd0, 0, 0, 2'd2, 2'd3, 0, 0, 0, 3'd0, 1); step("R3");
      // R4 clamp corners
      put(32'h8000_0001, 32'd40, 0, 0, 0, 2'd0, 1, 0, 0, 0, 0, 1, 0, 3'd0, 1); step("R4");
      put(32'h8000_0001, 32'd32, 0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 1); step("R4");
      put(32'h8000_0001, 32'd31, 0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 1); step("R4");
      put(32'h0000_0001, 0, 0, 16'hFFFF, 1, 2'd0, 1, 0, 0, 0, 0, 1, 0, 3'd0, 1); step("R4");
      // R5 wrap corners
      put(32'h8000_0001, 32'd32, 0, 0, 0, 2'd0, 1, 0, 0, 0, 1, 1, 0, 3'd0, 1); step("R5");
      put(32'h8000_0001, 32'd33, 0, 0, 0, 2'd0, 1, 0, 0, 0, 1, 1, 0, 3'd0, 1); step("R5");
      // R6 saturation
      put(32'hFFFF_FFFF, 0, 0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 1, 3'd0, 1); step("R6");
      put(32'hFFFF_FFF0, 0, 0, 0, 0, 2'd0, 1, 0, 0, 0, 0, 0, 1, 3'd0, 1); step("R6");
      put(32'hFFFF_FFF0, 0, 0, 0, 0, 2'd0, 1, 0, 0, 0, 0, 0, 0, 3'd0, 1); step("R6");
      // R7 merges, plain and lane-saturated
      put(32'h0001_2345, 32'd4, 32'hAABB_CCDD, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd1, 1); step("R7");
      put(32'h0001_2345, 32'd4, 32'hAABB_CCDD, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 1, 3'd2, 1); step("R7");
      put(32'h0000_0345, 32'd0, 32'hAABB_CCDD, 0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 1, 3'd3, 1); step("R7");
      put(32'hFFFF_FF00, 32'd0, 32'hAABB_CCDD, 0, 0, 2'd0, 1, 0, 0, 0, 0, 1, 1, 3'd4, 1); step("R7");
      // R8 accumulate
      put(32'h7FFF_FFFF, 32'd0, 32'h0000_0010, 0, 0, 2'd0, 1, 0, 0, 0, 0, 1, 1, 3'd5, 1); step("R8");
      put(32'h0000_0100, 32'd4, 32'hFFFF_FFF0, 0, 0, 2'd0, 1, 0, 0, 0, 0, 1, 0, 3'd5, 1); step("R8");
      put(32'h0000_0100, 32'd4, 32'hFFFF_FFF0, 0, 0, 2'd0, 1, 0, 0, 0, 0, 0, 1, 3'd5, 1); step("R8");
      // R9 min/max with both comparison types
      put(32'h0000_0100, 32'd0, 32'hFFFF_FFF0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd6, 1); step("R9");
      put(32'h0000_0100, 32'd0, 32'hFFFF_FFF0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0, 3'd6, 1); step("R9");
      put(32'h0000_0100, 32'd0, 32'hFFFF_FFF0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd7, 1); step("R9");
      // R10 flags hold while disabled, then zero result
      put(32'hFFFF_FFFF, 0, 0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 1, 3'd0, 1); step("R10");
      put(32'h0000_0000, 0, 0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 0); step("R10");
      put(32'h0000_0000, 0, 0, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1, 0, 3'd0, 1); step("R10");

      for (int i = 0; i < 4000; i++) begin
         logic [31:0] bb;
         bb = ($urandom_range(0, 3) == 0) ? $urandom() : 32'($urandom_range(0, 40));
         put($urandom(), bb, $urandom(), 16'($urandom_range(0, 70)), 1'($urandom_range(0, 1)),
             2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)),
             1'($urandom_range(0, 1)));
         step(rand_tag(op_sel, sat_en, count_wrap));
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule